// File: doc/BRIEF.md
# Power-Mode Clock Gating Controller

This block decides which peripheral units receive a clock. Software programs three gate registers over a single-cycle memory-mapped bus. One register is for normal running, one for sleep and one for deep sleep. Each register holds one enable bit per unit. The current power-mode code and an auto-gating enable input select which register drives a registered per-unit clock-enable vector. That vector goes to the clock-gate cells, which are outside this block.

The block also screens peripheral accesses. The address decoder reports an access as a unit index. If the selected enable bit for that unit is 0, the access is not forwarded and is answered with an error flag in the same cycle. Otherwise it is forwarded to the unit.

Top module: `pcg_top`

## Requirements
- R1: While reset is asserted and after its release, all three gate registers read 0 and the clock-enable vector is 0.
- R2: The run register is at byte offset 0x104, the sleep register at 0x114 and the deep-sleep register at 0x124. A write stores the data, and a read in the same cycle as the request returns the stored value. The bus ready equals the request in every cycle.
- R3: Only bits 0, 4, 8, 16, 17, 18, 19 and 24 are writable. All other bit positions read 0 and ignore writes. Accesses to any other offset read 0 and change no register. Read data is 0 whenever there is no read request.
- R4: Unit indices 0 to 7 map to register bits 0, 4, 8, 16, 17, 18, 19 and 24 in that order. Clock-enable bit u follows register bit UNIT_BIT[u].
- R5: When auto-gating is off, the run register drives the enable vector in every power mode.
- R6: When auto-gating is on, mode code 01 selects the sleep register and code 10 selects the deep-sleep register. Codes 00 and 11 select the run register.
- R7: The enable vector is registered. It reflects a register write or a mode/auto change from the clock edge after the one that takes the change in.
- R8: A peripheral request to a unit whose enable bit is 0 raises the error flag and is not forwarded. A request to an enabled unit is forwarded with no error. Without a request both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_mode | input | 2 | Power mode: 00 run, 01 sleep, 10 deep sleep, 11 run |
| auto_gate_en | input | 1 | Lets the sleep and deep-sleep registers take effect |
| reg_req | input | 1 | Register bus request |
| reg_wr | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, 0 unless reading |
| reg_ready | output | 1 | Access completes this cycle |
| per_req | input | 1 | Peripheral access request |
| per_unit | input | 3 | Decoded target unit index |
| per_fwd | output | 1 | Access forwarded to the unit |
| per_err | output | 1 | Access answered with bus fault |
| clk_en | output | 8 | Per-unit clock enable |

## Verification
The assertions assume that the unit index is always below the unit count. They also assume that the mode and auto-gating inputs, like the bus inputs, are held stable around each clock edge. The stimulus drives every input shortly after the falling edge and uses only unit indices 0 to 7. It covers all four mode codes with auto-gating both on and off. It writes all-ones, sparse patterns and unmapped offsets, so that reserved bits and stray addresses are exercised without breaking those assumptions.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int NUM_UNITS = 8;
  localparam int DW        = 32;
  localparam int AW        = 12;
  localparam int UW        = $clog2(NUM_UNITS);
  localparam int NREG      = 3;

  localparam logic [AW-1:0] OFF_RUN  = 12'h104;
  localparam logic [AW-1:0] OFF_SLP  = 12'h114;
  localparam logic [AW-1:0] OFF_DSL  = 12'h124;

  // Register bit behind each unit index; the order is decoded by the selector.
  localparam int UNIT_BIT [NUM_UNITS] = '{0, 4, 8, 16, 17, 18, 19, 24};

  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_SLP  = 2'b01,
    PM_DSL  = 2'b10,
    PM_ALT  = 2'b11
  } pwr_mode_e;

  function automatic logic [DW-1:0] gate_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int u = 0; u < NUM_UNITS; u++) m[UNIT_BIT[u]] = 1'b1;
    return m;
  endfunction

  function automatic logic [NUM_UNITS-1:0] unit_view(input logic [DW-1:0] r);
    logic [NUM_UNITS-1:0] v;
    for (int u = 0; u < NUM_UNITS; u++) v[u] = r[UNIT_BIT[u]];
    return v;
  endfunction
endpackage

// File: rtl/pcg_regs.sv
module pcg_regs
  import pcg_pkg::*;
#(
  parameter int            P_DW   = DW,
  parameter int            P_AW   = AW,
  parameter logic [AW-1:0] P_ORUN = OFF_RUN,
  parameter logic [AW-1:0] P_OSLP = OFF_SLP,
  parameter logic [AW-1:0] P_ODSL = OFF_DSL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_req,
  input  logic            reg_wr,
  input  logic [P_AW-1:0] reg_addr,
  input  logic [P_DW-1:0] reg_wdata,
  output logic [P_DW-1:0] reg_rdata,
  output logic [P_DW-1:0] run_q,
  output logic [P_DW-1:0] slp_q,
  output logic [P_DW-1:0] dsl_q
);
  localparam logic [P_DW-1:0] MASK = gate_mask();
  localparam logic [P_AW-1:0] OFFS [NREG] = '{P_ORUN, P_OSLP, P_ODSL};

  logic [P_DW-1:0] regs_q [NREG];
  logic [P_DW-1:0] regs_d [NREG];
  logic [NREG-1:0] hit;
  logic [NREG-1:0] wr_en;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign hit[i]    = (reg_addr == OFFS[i]);
    assign wr_en[i]  = reg_req & reg_wr & hit[i];
    assign regs_d[i] = reg_wdata & MASK;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        regs_q[i] <= '0;
      else if (wr_en[i]) regs_q[i] <= regs_d[i];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_req && !reg_wr) begin
      for (int i = 0; i < NREG; i++)
        if (hit[i]) reg_rdata = regs_q[i];
    end
  end

  assign run_q = regs_q[0];
  assign slp_q = regs_q[1];
  assign dsl_q = regs_q[2];

  // R3: reserved positions never show up on the read bus
  a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~MASK) == '0);
  // R3: no read request means zero read data
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req && !reg_wr) |-> reg_rdata == '0);
  // R2: a register not addressed by a write keeps its value
  a_r2_hold_run: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req && reg_wr && reg_addr == P_ORUN) |=> $stable(run_q));
endmodule

// File: rtl/pcg_sel.sv
module pcg_sel
  import pcg_pkg::*;
#(
  parameter int P_DW = DW,
  parameter int P_NU = NUM_UNITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      pwr_mode,
  input  logic            auto_gate_en,
  input  logic [P_DW-1:0] run_q,
  input  logic [P_DW-1:0] slp_q,
  input  logic [P_DW-1:0] dsl_q,
  output logic [P_NU-1:0] clk_en
);
  pwr_mode_e       mode;
  logic [P_DW-1:0] src;
  logic [P_NU-1:0] en_d;
  logic [P_NU-1:0] en_q;

  assign mode = pwr_mode_e'(pwr_mode);

  always_comb begin
    src = run_q;
    if (auto_gate_en) begin
      unique case (mode)
        PM_SLP:  src = slp_q;
        PM_DSL:  src = dsl_q;
        default: src = run_q;
      endcase
    end
    en_d = unit_view(src);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign clk_en = en_q;

  // R4: an enabled unit must have been enabled in some gate register last cycle
  a_r4_subset: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (clk_en & ~$past(unit_view(run_q | slp_q | dsl_q))) == '0);
  // R5: with auto-gating off and run register steady, the vector tracks it
  a_r5_run_only: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_gate_en |=> clk_en == unit_view($past(run_q)));
endmodule

// File: rtl/pcg_guard.sv
module pcg_guard
  import pcg_pkg::*;
#(
  parameter int P_NU = NUM_UNITS,
  parameter int P_UW = UW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            per_req,
  input  logic [P_UW-1:0] per_unit,
  input  logic [P_NU-1:0] clk_en,
  output logic            per_fwd,
  output logic            per_err
);
  logic live;

  assign live    = clk_en[per_unit];
  assign per_fwd = per_req &  live;
  assign per_err = per_req & ~live;

  // R8: every request gets exactly one outcome
  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    per_req |-> $onehot({per_fwd, per_err}));
  // R8: nothing happens without a request
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !per_req |-> !(per_fwd || per_err));
endmodule

// File: rtl/pcg_top.sv
module pcg_top
  import pcg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           pwr_mode,
  input  logic                 auto_gate_en,
  input  logic                 reg_req,
  input  logic                 reg_wr,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic                 reg_ready,
  input  logic                 per_req,
  input  logic [UW-1:0]        per_unit,
  output logic                 per_fwd,
  output logic                 per_err,
  output logic [NUM_UNITS-1:0] clk_en
);
  logic [DW-1:0] run_q, slp_q, dsl_q;

  assign reg_ready = reg_req;

  pcg_regs u_regs (
    .clk, .rst_n, .reg_req, .reg_wr, .reg_addr, .reg_wdata,
    .reg_rdata, .run_q, .slp_q, .dsl_q
  );

  pcg_sel u_sel (
    .clk, .rst_n, .pwr_mode, .auto_gate_en,
    .run_q, .slp_q, .dsl_q, .clk_en
  );

  pcg_guard u_guard (
    .clk, .rst_n, .per_req, .per_unit, .clk_en, .per_fwd, .per_err
  );

  // R1: the enable vector is clear on the first edge after reset release
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> clk_en == '0);
endmodule

// File: tb/tb_pcg_top.sv
`timescale 1ns/1ps
module tb_pcg_top;
  localparam real HALF = 4.0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  pwr_mode;
  logic        auto_gate_en;
  logic        reg_req, reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        reg_ready;
  logic        per_req;
  logic [2:0]  per_unit;
  logic        per_fwd, per_err;
  logic [7:0]  clk_en;

  pcg_top dut (.*);

  always #(HALF) clk = ~clk;

  int    errs = 0;
  int    checks = 0;
  bit    done = 0;
  string cur = "R1";

  int          pos [8] = '{0, 4, 8, 16, 17, 18, 19, 24};
  logic [11:0] offs [3] = '{12'h104, 12'h114, 12'h124};
  logic [31:0] m_reg [3];
  logic [7:0]  m_en;
  logic [31:0] mask;
  int          s;

  initial begin
    mask = 0;
    foreach (pos[u]) mask[pos[u]] = 1'b1;
  end

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_reg[k]) m_reg[k] <= 0;
      m_en <= 0;
    end else begin
      s = 0;
      if (auto_gate_en && pwr_mode == 2'b01) s = 1;
      if (auto_gate_en && pwr_mode == 2'b10) s = 2;
      foreach (pos[u]) m_en[u] <= m_reg[s][pos[u]];
      if (reg_req && reg_wr)
        foreach (offs[k]) if (reg_addr == offs[k]) m_reg[k] <= reg_wdata & mask;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", cur, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [31:0] exp_rd;
    if (rst_n === 1'b1 && !done) begin
      exp_rd = 0;
      if (reg_req && !reg_wr)
        foreach (offs[k]) if (reg_addr == offs[k]) exp_rd = m_reg[k];
      chk("clk_en", {24'd0, clk_en}, {24'd0, m_en});
      chk("rdata", reg_rdata, exp_rd);
      chk("ready", {31'd0, reg_ready}, {31'd0, reg_req});
      chk("fwd", {31'd0, per_fwd}, {31'd0, per_req & m_en[per_unit]});
      chk("err", {31'd0, per_err}, {31'd0, per_req & ~m_en[per_unit]});
    end
  end

  task automatic step(); @(negedge clk); #1; endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    step(); reg_req = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    step(); reg_req = 0; reg_wr = 0;
  endtask

  task automatic rd(logic [11:0] a);
    step(); reg_req = 1; reg_wr = 0; reg_addr = a;
    step(); reg_req = 0;
  endtask

  task automatic sweep_units();
    for (int u = 0; u < 8; u++) begin
      step(); per_req = 1; per_unit = u[2:0];
    end
    step(); per_req = 0;
  endtask

  initial begin
    #(HALF * 2.0 * 200000.0);
    if (!done) begin
      done = 1; errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pwr_mode = 0; auto_gate_en = 0; reg_req = 0; reg_wr = 0;
    reg_addr = 0; reg_wdata = 0; per_req = 0; per_unit = 0;
    repeat (3) @(negedge clk);
    cur = "R1";
    chk("reset clk_en", {24'd0, clk_en}, 32'd0);
    #1 rst_n = 1;
    rd(12'h104); rd(12'h114); rd(12'h124); sweep_units();

    cur = "R2";
    wr(12'h104, 32'h0000_0011); wr(12'h114, 32'h010F_0000); wr(12'h124, 32'h0008_0101);
    rd(12'h104); rd(12'h114); rd(12'h124);

    cur = "R3";
    wr(12'h114, 32'hFFFF_FFFF); rd(12'h114);
    wr(12'h108, 32'hFFFF_FFFF); wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h108); rd(12'h000); rd(12'h104); rd(12'h124);
    wr(12'h104, 32'hFEF0_FEEE); rd(12'h104);

    cur = "R4";
    for (int u = 0; u < 8; u++) begin
      wr(12'h104, 32'd1 << pos[u]); step(); sweep_units();
    end

    cur = "R5";
    wr(12'h104, 32'h0001_0010); wr(12'h114, 32'h0100_0001); wr(12'h124, 32'h000E_0100);
    auto_gate_en = 0;
    for (int m = 0; m < 4; m++) begin
      step(); pwr_mode = m[1:0]; step(); sweep_units();
    end

    cur = "R6";
    step(); auto_gate_en = 1;
    for (int m = 0; m < 4; m++) begin
      step(); pwr_mode = m[1:0]; step(); sweep_units();
    end

    cur = "R7";
    step(); pwr_mode = 2'b10; step(); pwr_mode = 2'b01; step(); auto_gate_en = 0;
    step(); pwr_mode = 2'b10; auto_gate_en = 1;
    wr(12'h124, 32'h0100_0000); step(); wr(12'h124, 32'h0); step(); step();

    cur = "R8";
    wr(12'h104, 32'h0105_0010); step(); auto_gate_en = 0;
    step(); step(); sweep_units();
    step(); per_req = 1; per_unit = 3'd1; reg_req = 1; reg_wr = 1;
    reg_addr = 12'h104; reg_wdata = 32'h0;
    step(); reg_req = 0; reg_wr = 0; step(); step(); per_req = 0;
    step(); step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule